// File: doc/BRIEF.md
# Single-Channel Block Mover with Bus Request/Grant

This engine copies a block of words without the processor touching each word. The host sets up a few registers: a memory address, a word count and, for copies, a second address. It then writes a control word that picks the mode and starts the run. The engine does not own the memory bus. It raises a request line and waits for the processor's grant before it drives any address or read/write strobe.

There are three data paths:
- **Inbound:** words arriving on a peripheral input port are written to memory.
- **Outbound:** words read from memory are handed to a peripheral output port.
- **Copy:** one memory region is copied to another.

There are two bus policies:
- **Burst:** the grant is held for the whole block.
- **Cycle-stealing:** the bus is handed back after every word. The engine waits until the processor has dropped the grant and the peripheral is ready, and only then asks again.

When the block is done, a sticky interrupt is raised.

Top module: `dma_engine`

## Requirements
- R1: After reset, the request line, both memory strobes, the interrupt and all register read-backs are zero.
- R2: Register select 0 is the memory address, select 1 is the word count and select 2 is the copy destination address. Each reads back the value last written to it.
- R3: A memory read or write strobe is only driven in a cycle where the grant input is high.
- R4: In inbound mode (control bit 2 = 0, bit 3 = 0), each word accepted on the input port is written to consecutive memory addresses, starting at the programmed address.
- R5: In outbound mode (control bit 2 = 1), consecutive memory words starting at the programmed address appear in order on the output port.
- R6: In copy mode (control bit 3 = 1, which overrides bit 2), word i is read from address+i and written to destination+i.
- R7: In burst mode (control bit 1 = 1), the request line rises exactly once per block and falls after the last word.
- R8: In cycle-stealing mode (control bit 1 = 0), the request line is asserted once per word, and never while the peripheral is not ready.
- R9: The count decrements by one per word, and the address advances by one per word. When the count reaches zero, the interrupt is raised. After the block, the count reads 0 and the address reads start+count.
- R10: Starting with a count of zero raises the interrupt without ever asserting the request line.
- R11: The interrupt stays set until the host writes select 3 with bit 4 set. Status bit 5 mirrors the interrupt and bit 6 is busy.
- R12: While a transfer is active, writes to the address and count registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Host register write strobe |
| regSel | input | 2 | Register select: 0 address, 1 count, 2 destination, 3 control/status |
| regWdata | input | DATA_W | Host write data |
| regRdata | output | DATA_W | Read data of the selected register |
| br | output | 1 | Bus request to the processor |
| bg | input | 1 | Bus grant from the processor |
| memAddr | output | ADDR_W | Memory address |
| memRd | output | 1 | Memory read strobe (data returns the next cycle) |
| memWr | output | 1 | Memory write strobe |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data |
| pInValid | input | 1 | Inbound peripheral word available |
| pInReady | output | 1 | Engine accepts the inbound word |
| pInData | input | DATA_W | Inbound peripheral word |
| pOutValid | output | 1 | Outbound word available |
| pOutReady | input | 1 | Peripheral accepts the outbound word |
| pOutData | output | DATA_W | Outbound word |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The bench builds the engine with ADDR_W=6, DATA_W=16 and CNT_W=5. This gives a 64-word model memory in which inbound, outbound and copy regions can all be laid side by side and checked word by word. The five-bit count lets every block finish within a few dozen cycles, so all six combinations of data path and bus policy fit in a single run. It also lets the zero-count start and a transfer held up by an idle peripheral be checked. The processor model grants one cycle after a request and withdraws one cycle after release. This exposes any strobe that leaks outside the grant and any stale-grant re-request in cycle-stealing mode.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_AUX  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam int CB_START = 0;
  localparam int CB_BURST = 1;
  localparam int CB_DIR   = 2;
  localparam int CB_COPY  = 3;
  localparam int CB_CLR   = 4;
  localparam int SB_IRQ   = 5;
  localparam int SB_BUSY  = 6;

  typedef struct packed {
    logic memRd;
    logic memWr;
    logic selAux;
    logic useLatched;
    logic latch;
    logic step;
    logic setIrq;
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_GATE, S_REQ, S_MOVE, S_LATCH, S_WRITE, S_PUSH
  } dmaState_t;
endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  dpCtl_t            ctl,
  input  logic              busy,
  input  logic [DATA_W-1:0] pInData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] pOutData,
  output logic              startPulse,
  output logic              modeBurst,
  output logic              modeDir,
  output logic              modeCopy,
  output logic              cntZero,
  output logic              cntOne,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addrReg, auxReg;
  logic [CNT_W-1:0]  cntReg;
  logic [DATA_W-1:0] dataReg;
  logic wrAddr, wrCnt, wrAux, wrCtrl, clrReq;

  assign wrAddr     = regWe && regSel == SEL_ADDR && !busy;
  assign wrCnt      = regWe && regSel == SEL_CNT  && !busy;
  assign wrAux      = regWe && regSel == SEL_AUX  && !busy;
  assign wrCtrl     = regWe && regSel == SEL_CTRL;
  assign clrReq     = wrCtrl && regWdata[CB_CLR];
  assign startPulse = wrCtrl && regWdata[CB_START] && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      auxReg    <= '0;
      cntReg    <= '0;
      dataReg   <= '0;
      modeBurst <= 1'b0;
      modeDir   <= 1'b0;
      modeCopy  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wrAddr)        addrReg <= regWdata[ADDR_W-1:0];
      else if (ctl.step) addrReg <= addrReg + 1'b1;

      if (wrAux)                      auxReg <= regWdata[ADDR_W-1:0];
      else if (ctl.step && modeCopy)  auxReg <= auxReg + 1'b1;

      if (wrCnt)         cntReg <= regWdata[CNT_W-1:0];
      else if (ctl.step) cntReg <= cntReg - 1'b1;

      if (startPulse) begin
        modeBurst <= regWdata[CB_BURST];
        modeDir   <= regWdata[CB_DIR];
        modeCopy  <= regWdata[CB_COPY];
      end

      if (ctl.latch) dataReg <= memRdata;

      if (ctl.setIrq)  irq <= 1'b1;
      else if (clrReq) irq <= 1'b0;
    end
  end

  assign cntZero  = cntReg == '0;
  assign cntOne   = cntReg == CNT_ONE;
  assign memAddr  = ctl.selAux ? auxReg : addrReg;
  assign memWdata = ctl.useLatched ? dataReg : pInData;
  assign pOutData = dataReg;

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_ADDR: regRdata[ADDR_W-1:0] = addrReg;
      SEL_CNT:  regRdata[CNT_W-1:0]  = cntReg;
      SEL_AUX:  regRdata[ADDR_W-1:0] = auxReg;
      default: begin
        regRdata[CB_BURST] = modeBurst;
        regRdata[CB_DIR]   = modeDir;
        regRdata[CB_COPY]  = modeCopy;
        regRdata[SB_IRQ]   = irq;
        regRdata[SB_BUSY]  = busy;
      end
    endcase
  end

  // R12
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !ctl.step |=> $stable(addrReg));
  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq && !clrReq |=> irq);
  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> cntReg == $past(cntReg) - 1'b1);
endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startPulse,
  input  logic   modeBurst,
  input  logic   modeDir,
  input  logic   modeCopy,
  input  logic   cntZero,
  input  logic   cntOne,
  input  logic   bg,
  input  logic   pInValid,
  input  logic   pOutReady,
  output logic   br,
  output logic   busy,
  output logic   pInReady,
  output logic   pOutValid,
  output dpCtl_t ctl
);
  dmaState_t state, nextState;
  logic devReady;

  assign devReady = modeCopy || modeBurst || (modeDir ? pOutReady : pInValid);
  assign busy     = state != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    br        = 1'b0;
    pInReady  = 1'b0;
    pOutValid = 1'b0;
    unique case (state)
      S_IDLE: if (startPulse) nextState = S_ARM;
      S_ARM: begin
        if (cntZero) begin
          ctl.setIrq = 1'b1;
          nextState  = S_IDLE;
        end else nextState = S_GATE;
      end
      S_GATE: if (!bg && devReady) nextState = S_REQ;
      S_REQ: begin
        br = 1'b1;
        if (bg) nextState = S_MOVE;
      end
      S_MOVE: begin
        br = 1'b1;
        if (modeCopy || modeDir) begin
          ctl.memRd = 1'b1;
          nextState = S_LATCH;
        end else begin
          pInReady = 1'b1;
          if (pInValid) begin
            ctl.memWr = 1'b1;
            ctl.step  = 1'b1;
          end
        end
      end
      S_LATCH: begin
        br        = 1'b1;
        ctl.latch = 1'b1;
        nextState = modeCopy ? S_WRITE : S_PUSH;
      end
      S_WRITE: begin
        br             = 1'b1;
        ctl.memWr      = 1'b1;
        ctl.selAux     = 1'b1;
        ctl.useLatched = 1'b1;
        ctl.step       = 1'b1;
      end
      S_PUSH: begin
        br        = modeBurst;
        pOutValid = 1'b1;
        if (pOutReady) ctl.step = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
    if (ctl.step) begin
      if (cntOne) begin
        ctl.setIrq = 1'b1;
        nextState  = S_IDLE;
      end else nextState = modeBurst ? S_MOVE : S_GATE;
    end
  end

  // R3
  bus_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memRd || ctl.memWr) |-> bg);
  // R8
  steal_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step && !modeBurst |=> !br);
  // R7
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step && modeBurst && !cntOne |=> br);
  // R10
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == S_ARM && cntZero |=> !br && !busy);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              br,
  input  logic              bg,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              pInValid,
  output logic              pInReady,
  input  logic [DATA_W-1:0] pInData,
  output logic              pOutValid,
  input  logic              pOutReady,
  output logic [DATA_W-1:0] pOutData,
  output logic              irq
);
  dpCtl_t ctl;
  logic busy, startPulse, modeBurst, modeDir, modeCopy, cntZero, cntOne;

  dma_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .ctl(ctl), .busy(busy),
    .pInData(pInData), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .pOutData(pOutData), .startPulse(startPulse),
    .modeBurst(modeBurst), .modeDir(modeDir), .modeCopy(modeCopy),
    .cntZero(cntZero), .cntOne(cntOne), .irq(irq)
  );

  dma_control u_ctl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .modeBurst(modeBurst),
    .modeDir(modeDir), .modeCopy(modeCopy), .cntZero(cntZero),
    .cntOne(cntOne), .bg(bg), .pInValid(pInValid), .pOutReady(pOutReady),
    .br(br), .busy(busy), .pInReady(pInReady), .pOutValid(pOutValid),
    .ctl(ctl)
  );

  assign memRd = ctl.memRd;
  assign memWr = ctl.memWr;
endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 5;

  typedef struct packed {
    logic       burst;
    logic       dir;
    logic       copy;
    logic [5:0] addr;
    logic [5:0] aux;
    logic [4:0] cnt;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 6'd0,  6'd0,  5'd4},
    '{1'b0, 1'b0, 1'b0, 6'd8,  6'd0,  5'd3},
    '{1'b1, 1'b1, 1'b0, 6'd16, 6'd0,  5'd5},
    '{1'b0, 1'b1, 1'b0, 6'd24, 6'd0,  5'd2},
    '{1'b1, 1'b0, 1'b1, 6'd16, 6'd40, 5'd5},
    '{1'b0, 1'b0, 1'b1, 6'd0,  6'd48, 5'd4},
    '{1'b1, 1'b0, 1'b0, 6'd32, 6'd0,  5'd1}
  };

  logic clk = 0, rstN = 0, regWe = 0, bg = 0;
  logic [1:0] regSel = 0;
  logic [DATA_W-1:0] regWdata = 0, regRdata, memWdata, pOutData, pInData;
  logic [DATA_W-1:0] memRdata = 0;
  logic [ADDR_W-1:0] memAddr;
  logic br, memRd, memWr, pInReady, pOutValid, irq;
  logic srcEn = 0, sinkEn = 0, brPrev = 0;
  logic [DATA_W-1:0] mem [64];
  logic [DATA_W-1:0] sinkBuf [32];
  logic [DATA_W-1:0] srcBase = 0;
  int srcIdx = 0, sinkIdx = 0, reqCount = 0, contention = 0;
  int checks = 0, fails = 0;
  logic [DATA_W-1:0] rd;

  always #5 clk = ~clk;

  dma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .br(br), .bg(bg),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .memRdata(memRdata), .pInValid(srcEn), .pInReady(pInReady),
    .pInData(pInData), .pOutValid(pOutValid), .pOutReady(sinkEn),
    .pOutData(pOutData), .irq(irq)
  );

  assign pInData = srcBase + DATA_W'(srcIdx);

  always @(posedge clk) begin
    bg <= rstN ? br : 1'b0;
    brPrev <= br;
    if (br && !brPrev) reqCount <= reqCount + 1;
    if ((memRd || memWr) && !bg) contention <= contention + 1;
    if (memWr) mem[memAddr] <= memWdata;
    if (memRd) memRdata <= mem[memAddr];
    if (srcEn && pInReady) srcIdx <= srcIdx + 1;
    if (pOutValid && sinkEn) begin
      sinkBuf[sinkIdx[4:0]] <= pOutData;
      sinkIdx <= sinkIdx + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regWe = 1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [DATA_W-1:0] d);
    regSel = sel;
    #1 d = regRdata;
  endtask

  task automatic waitIrq();
    for (int i = 0; i < 400; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = DATA_W'(16'h0A00 + i * 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 br", br, 0);
    chk("R1 irq", irq, 0);
    chk("R1 strobes", {memRd, memWr}, 0);
    for (int s = 0; s < 4; s++) begin
      regRead(2'(s), rd);
      chk("R1 regs", rd, 0);
    end
    rstN = 1;
    @(negedge clk);

    // R2 register readback
    regWrite(2'd0, 16'h002A); regWrite(2'd1, 16'h0007); regWrite(2'd2, 16'h0015);
    regRead(2'd0, rd); chk("R2 addr", rd, 16'h2A);
    regRead(2'd1, rd); chk("R2 count", rd, 16'h07);
    regRead(2'd2, rd); chk("R2 aux", rd, 16'h15);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      vec_t t = VECS[v];
      srcBase = DATA_W'(16'h100 * (v + 1));
      srcIdx = 0; sinkIdx = 0; reqCount = 0;
      srcEn = 1; sinkEn = 1;
      regWrite(2'd0, DATA_W'(t.addr));
      regWrite(2'd2, DATA_W'(t.aux));
      regWrite(2'd1, DATA_W'(t.cnt));
      regWrite(2'd3, {12'd0, t.copy, t.dir, t.burst, 1'b1});
      waitIrq();
      repeat (2) @(negedge clk);
      for (int i = 0; i < int'(t.cnt); i++) begin
        if (t.copy)
          chk("R6 copy", mem[t.aux + 6'(i)], mem[t.addr + 6'(i)]);
        else if (t.dir)
          chk("R5 outbound", sinkBuf[i], mem[t.addr + 6'(i)]);
        else
          chk("R4 inbound", mem[t.addr + 6'(i)], srcBase + DATA_W'(i));
      end
      if (t.burst) chk("R7 one request", reqCount, 1);
      else         chk("R8 per-unit requests", reqCount, int'(t.cnt));
      chk("R7 released", br, 0);
      chk("R9 irq", irq, 1);
      regRead(2'd1, rd); chk("R9 count zero", rd, 0);
      regRead(2'd0, rd); chk("R9 addr end", rd, DATA_W'(t.addr + 6'(t.cnt)));
      regWrite(2'd3, 16'h0010);
      chk("R11 cleared", irq, 0);
    end
    chk("R3 no contention", contention, 0);

    // R10 zero count
    reqCount = 0;
    regWrite(2'd1, 16'h0000);
    regWrite(2'd3, 16'h0003);
    repeat (3) @(negedge clk);
    chk("R10 irq", irq, 1);
    chk("R10 no request", reqCount, 0);
    // R11 sticky
    repeat (5) @(negedge clk);
    chk("R11 sticky", irq, 1);
    regRead(2'd3, rd); chk("R11 status bit", rd[5], 1);
    regWrite(2'd3, 16'h0010);
    chk("R11 clear", irq, 0);

    // R12 writes ignored while busy; R8 no request while peripheral idle
    srcEn = 0; srcIdx = 0; srcBase = 16'h0777; reqCount = 0;
    regWrite(2'd0, 16'd56);
    regWrite(2'd1, 16'd2);
    regWrite(2'd3, 16'h0001);
    repeat (5) @(negedge clk);
    regRead(2'd3, rd); chk("R11 busy bit", rd[6], 1);
    chk("R8 gated request", reqCount, 0);
    regWrite(2'd0, 16'd3);
    regWrite(2'd1, 16'd9);
    regRead(2'd0, rd); chk("R12 addr kept", rd, 16'd56);
    regRead(2'd1, rd); chk("R12 count kept", rd, 16'd2);
    srcEn = 1;
    waitIrq();
    repeat (2) @(negedge clk);
    chk("R12 word0", mem[56], 16'h0777);
    chk("R12 word1", mem[57], 16'h0778);
    chk("R3 no contention end", contention, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule